// File: doc/BRIEF.md
# Single-Frame Register Network Port

This block is a bus-mapped peripheral that passes whole Ethernet frames, one at a time, between a host register interface and a pair of byte streams on the network side. Each direction has a single buffer large enough for one maximum-length frame. The host collects a received frame by reading a data port once per byte. It sends a frame by first writing the frame length and then writing the payload bytes to a second data port. When the last byte is written, the frame leaves on the outgoing byte stream.

A three-bit event register records transmit completion, receive completion and a self-test event. Any set bit raises a level interrupt. A busy flag stops new frames from being accepted until the host acknowledges what is pending. Writing the event register clears one event per write in a fixed order of priority. Its self-test bit performs a soft reset of the whole block.

Top module: `nif_top`

## Requirements
- R1: After reset, busy reads 1, both byte counts read 0, the event register reads 0, `irq` is low and `rx_ready` is low.
- R2: Only the low 6 address bits are decoded. Offsets 0x00 and 0x04 return an 8-character identifier packed little-endian, first character in bits 7:0 of 0x00. Offset 0x18, offset 0x20 and unmapped offsets read 0.
- R3: A frame is accepted only while busy (0x08) is 0 and the receive count (0x0C) is below the maximum frame length. Otherwise `rx_ready` stays low and the receive count does not change. The byte flagged `rx_last` loads the receive count with the frame length, sets busy, and sets event bit 1 (receive done).
- R4: Each read of 0x1C returns the next stored byte in arrival order and decrements the receive count. When the count is 0, a read returns 0 and changes nothing.
- R5: A write to 0x10 loads the transmit count when the value is at most the maximum frame length and loads 0 otherwise. Either form restarts the byte position at 0.
- R6: Each write to 0x20 stores bits 7:0. When the number of stored bytes equals the transmit count, the frame is streamed out, the transmit count returns to 0, event bit 0 (transmit done) is set, and busy is set.
- R7: Writes to 0x20 are ignored while the transmit count is 0 and while a frame is still streaming out.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold. `tx_last` marks only the final byte.
- R9: A write to the event register (0x14) clears bit 0 if wdata bit 0 is set. Otherwise it clears bit 1 if wdata bit 1 is set. Only that single action is taken.
- R10: A write to 0x14 with wdata bits 1:0 clear and bit 31 set performs a soft reset of counts, positions and events, then sets event bit 31 and busy.
- R11: A read of 0x14 returns the current events and then clears bit 31. After any write to 0x14, busy equals 1 if any event bit remains set and 0 otherwise.
- R12: `irq` is high exactly when at least one event bit is set.
- R13: Writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change nothing.
- R14: A received frame longer than the maximum frame length is accepted in full on the stream, but only its first maximum-length bytes are kept, and the receive count equals the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block takes the incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |

## Verification
The properties assume that the host never issues a read and a write in the same cycle. They also assume that no soft-reset write lands in the cycle a received frame completes or while a frame is streaming out, since either would legitimately break the receive-done and stream-hold relations. The stimulus performs one bus access at a time, separated by idle cycles. It only requests a soft reset when both streams are idle. `ADDR_W` must be at least 6.

// File: rtl/nif_pkg.sv
package nif_pkg;
  localparam logic [5:0] A_ID0   = 6'h00;
  localparam logic [5:0] A_ID1   = 6'h04;
  localparam logic [5:0] A_BUSY  = 6'h08;
  localparam logic [5:0] A_RXCNT = 6'h0C;
  localparam logic [5:0] A_TXCNT = 6'h10;
  localparam logic [5:0] A_EVT   = 6'h14;
  localparam logic [5:0] A_INFO  = 6'h18;
  localparam logic [5:0] A_RXDAT = 6'h1C;
  localparam logic [5:0] A_TXDAT = 6'h20;

  localparam int EV_TX   = 0;
  localparam int EV_RX   = 1;
  localparam int EV_TEST = 31;

  function automatic logic [31:0] id_word(input logic [63:0] s, input bit upper);
    logic [31:0] w;
    for (int b = 0; b < 4; b++) begin
      w[8*b +: 8] = upper ? s[8*(3-b) +: 8] : s[8*(7-b) +: 8];
    end
    return w;
  endfunction
endpackage

// File: rtl/nif_rx_buf.sv
module nif_rx_buf #(
  parameter int MAX_FRAME = 1514,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             busy,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             rx_ready,
  input  logic             pop,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  localparam int IDX_W = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1;
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [7:0]       mem [MAX_FRAME];
  logic [CNT_W-1:0] fill_q, fill_d, cnt_q, cnt_d, ridx_q, ridx_d;
  logic             take, mem_we;

  assign rx_ready = !busy && (cnt_q < MAXC);
  assign take     = rx_valid && rx_ready;
  assign mem_we   = take && (fill_q < MAXC) && !soft_rst;

  always_comb begin
    fill_d = fill_q;
    cnt_d  = cnt_q;
    ridx_d = ridx_q;
    done   = 1'b0;
    if (pop && (cnt_q != '0)) begin
      cnt_d  = cnt_q - ONE;
      ridx_d = ridx_q + ONE;
    end
    if (take) begin
      if (rx_last) begin
        cnt_d  = (fill_q < MAXC) ? fill_q + ONE : MAXC;
        ridx_d = '0;
        fill_d = '0;
        done   = 1'b1;
      end else if (fill_q < MAXC) begin
        fill_d = fill_q + ONE;
      end
    end
    if (soft_rst) begin
      fill_d = '0;
      cnt_d  = '0;
      ridx_d = '0;
      done   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      cnt_q  <= '0;
      ridx_q <= '0;
    end else begin
      fill_q <= fill_d;
      cnt_q  <= cnt_d;
      ridx_q <= ridx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[fill_q[IDX_W-1:0]] <= rx_data;
  end

  assign rd_byte = (cnt_q != '0) ? mem[ridx_q[IDX_W-1:0]] : 8'h00;
  assign count   = cnt_q;
endmodule

// File: rtl/nif_tx_buf.sv
module nif_tx_buf #(
  parameter int MAX_FRAME = 1514,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             ld_cnt,
  input  logic             wr_byte,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready
);
  localparam int IDX_W = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [7:0]       mem [MAX_FRAME];
  logic [CNT_W-1:0] cnt_q, cnt_d, widx_q, widx_d, slen_q, slen_d, sptr_q, sptr_d;
  logic             snd_q, snd_d, store, at_end;

  assign store  = wr_byte && (cnt_q != '0) && !snd_q && !soft_rst;
  assign at_end = (sptr_q == slen_q - ONE);

  always_comb begin
    cnt_d  = cnt_q;
    widx_d = widx_q;
    slen_d = slen_q;
    sptr_d = sptr_q;
    snd_d  = snd_q;
    done   = 1'b0;
    if (snd_q && tx_ready) begin
      if (at_end) snd_d = 1'b0;
      else        sptr_d = sptr_q + ONE;
    end
    if (ld_cnt) begin
      cnt_d  = (wdata <= 32'(MAX_FRAME)) ? wdata[CNT_W-1:0] : '0;
      widx_d = '0;
    end
    if (store) begin
      if (widx_q + ONE == cnt_q) begin
        slen_d = cnt_q;
        sptr_d = '0;
        snd_d  = 1'b1;
        cnt_d  = '0;
        widx_d = '0;
        done   = 1'b1;
      end else begin
        widx_d = widx_q + ONE;
      end
    end
    if (soft_rst) begin
      cnt_d  = '0;
      widx_d = '0;
      slen_d = '0;
      sptr_d = '0;
      snd_d  = 1'b0;
      done   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      widx_q <= '0;
      slen_q <= '0;
      sptr_q <= '0;
      snd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      widx_q <= widx_d;
      slen_q <= slen_d;
      sptr_q <= sptr_d;
      snd_q  <= snd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[widx_q[IDX_W-1:0]] <= wdata[7:0];
  end

  assign count    = cnt_q;
  assign tx_valid = snd_q;
  assign tx_data  = mem[sptr_q[IDX_W-1:0]];
  assign tx_last  = snd_q && at_end;
endmodule

// File: rtl/nif_evt_ctl.sv
module nif_evt_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_evt,
  input  logic        rd_evt,
  input  logic [1:0]  wsel,
  input  logic        tx_done,
  input  logic        rx_done,
  output logic [31:0] evt,
  output logic        busy,
  output logic        irq
);
  logic txf_q, txf_d, rxf_q, rxf_d, tsf_q, tsf_d, busy_q, busy_d;

  always_comb begin
    txf_d  = txf_q;
    rxf_d  = rxf_q;
    tsf_d  = tsf_q;
    busy_d = busy_q;
    if (rd_evt) tsf_d = 1'b0;
    if (wr_evt) begin
      if (wsel[0])      txf_d = 1'b0;
      else if (wsel[1]) rxf_d = 1'b0;
    end
    if (soft_rst) begin
      txf_d  = 1'b0;
      rxf_d  = 1'b0;
      tsf_d  = 1'b1;
      busy_d = 1'b1;
    end else begin
      txf_d = txf_d | tx_done;
      rxf_d = rxf_d | rx_done;
      if (tx_done || rx_done) busy_d = 1'b1;
      else if (wr_evt)        busy_d = txf_d | rxf_d | tsf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txf_q  <= 1'b0;
      rxf_q  <= 1'b0;
      tsf_q  <= 1'b0;
      busy_q <= 1'b1;
    end else begin
      txf_q  <= txf_d;
      rxf_q  <= rxf_d;
      tsf_q  <= tsf_d;
      busy_q <= busy_d;
    end
  end

  assign evt  = {tsf_q, 29'd0, rxf_q, txf_q};
  assign busy = busy_q;
  assign irq  = txf_q | rxf_q | tsf_q;
endmodule

// File: rtl/nif_top.sv
module nif_top #(
  parameter int          ADDR_W    = 8,
  parameter int          MAX_FRAME = 1514,
  parameter logic [63:0] ID_STR    = "NETPORT1"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  import nif_pkg::*;

  localparam int CNT_W = $clog2(MAX_FRAME + 1);
  localparam logic [31:0] ID_W0 = id_word(ID_STR, 1'b0);
  localparam logic [31:0] ID_W1 = id_word(ID_STR, 1'b1);

  logic [1:0]       rsync_q;
  logic             rst_ns;
  logic [5:0]       reg_a;
  logic             addr_unused;
  logic             wr_evt, rd_evt, wr_txc, wr_txd, pop, soft_rst;
  logic             tx_done, rx_done, busy;
  logic [31:0]      evt;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [7:0]       rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  assign reg_a       = bus_addr[5:0];
  assign addr_unused = ^bus_addr;
  assign wr_evt   = bus_wr && (reg_a == A_EVT);
  assign rd_evt   = bus_rd && (reg_a == A_EVT);
  assign wr_txc   = bus_wr && (reg_a == A_TXCNT);
  assign wr_txd   = bus_wr && (reg_a == A_TXDAT);
  assign pop      = bus_rd && (reg_a == A_RXDAT);
  assign soft_rst = wr_evt && !bus_wdata[EV_TX] && !bus_wdata[EV_RX] && bus_wdata[EV_TEST];

  nif_evt_ctl u_evt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .soft_rst (soft_rst),
    .wr_evt   (wr_evt),
    .rd_evt   (rd_evt),
    .wsel     (bus_wdata[1:0]),
    .tx_done  (tx_done),
    .rx_done  (rx_done),
    .evt      (evt),
    .busy     (busy),
    .irq      (irq)
  );

  nif_rx_buf #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_ns),
    .soft_rst (soft_rst),
    .busy     (busy),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_last  (rx_last),
    .rx_ready (rx_ready),
    .pop      (pop),
    .rd_byte  (rx_byte),
    .count    (rx_cnt),
    .done     (rx_done)
  );

  nif_tx_buf #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_ns),
    .soft_rst (soft_rst),
    .ld_cnt   (wr_txc),
    .wr_byte  (wr_txd),
    .wdata    (bus_wdata),
    .count    (tx_cnt),
    .done     (tx_done),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_ready (tx_ready)
  );

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_rd) begin
      case (reg_a)
        A_ID0:   bus_rdata = ID_W0;
        A_ID1:   bus_rdata = ID_W1;
        A_BUSY:  bus_rdata = {31'd0, busy};
        A_RXCNT: bus_rdata = 32'(rx_cnt);
        A_TXCNT: bus_rdata = 32'(tx_cnt);
        A_EVT:   bus_rdata = evt;
        A_RXDAT: bus_rdata = {24'd0, rx_byte};
        default: bus_rdata = 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/nif_chk.sv
module nif_chk #(
  parameter int ADDR_W    = 8,
  parameter int MAX_FRAME = 1514,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              tx_ready,
  input logic              busy,
  input logic [31:0]       evt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [CNT_W-1:0]  tx_cnt
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_FRAME);
  logic at_evt;
  assign at_evt = (bus_addr[5:0] == 6'h14);

  // R3
  rx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_last && !(bus_wr && at_evt)) |=> (busy && evt[1] && rx_cnt != '0));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R6
  tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (evt[0] && busy && tx_cnt == '0));

  // R5
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= MAXC);

  // R9
  evt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_evt && bus_wdata[0]) |=> (!evt[0] && (evt[1] || !$past(evt[1]))));

  // R11
  test_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && at_evt) |=> !evt[31]);

  // R10
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_evt && bus_wdata[1:0] == 2'b00 && bus_wdata[31])
      |=> (evt == 32'h8000_0000 && busy && irq && rx_cnt == '0 && tx_cnt == '0));
endmodule

bind nif_top nif_chk #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME)) u_nif_chk (.*);

// File: tb/test_nif_top.sv
`timescale 1ns/1ps
module test_nif_top;
  localparam int MAXF = 8;
  localparam int AW   = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wr, bus_rd;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          irq, rx_valid, rx_last, rx_ready, tx_valid, tx_last, tx_ready;
  logic [7:0]    rx_data, tx_data;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nif_top #(.ADDR_W(AW), .MAX_FRAME(MAXF), .ID_STR("NETPORT1")) i_nif_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  function automatic logic [7:0] rpat(int n, int i);
    return 8'((n * 16 + i * 3 + 1) & 255);
  endfunction
  function automatic logic [7:0] tpat(int n, int i);
    return 8'((n * 7 + i * 5 + 2) & 255);
  endfunction

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_eq(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    eq(req, v, exp);
  endtask

  task automatic push_rx(input int n, input int limit, output int got);
    int waited = 0;
    got = 0;
    while (got < n && waited < limit) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = rpat(n, got); rx_last = (got == n - 1);
      #1;
      if (rx_ready) got++;
      else waited++;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic send_tx(input int n);
    wr(8'h10, n);
    for (int i = 0; i < n; i++) wr(8'h20, {24'd0, tpat(n, i)});
  endtask

  task automatic drain_tx(input int n, input logic [7:0] first);
    int got = 0;
    int cyc = 0;
    while (got < n && cyc < 200) begin
      @(negedge clk);
      tx_ready = (cyc % 3 != 1);
      #1;
      if (tx_valid && tx_ready) begin
        eq("R6 tx byte", {24'd0, tx_data}, {24'd0, (got == 0) ? first : tpat(n, got)});
        eq("R8 tx last", {31'd0, tx_last}, {31'd0, (got == n - 1)});
        got++;
      end
      cyc++;
    end
    @(negedge clk);
    tx_ready = 1'b0;
    #1;
    eq("R6 tx frame length", got, n);
    eq("R6 tx idle after frame", {31'd0, tx_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int got;
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    eq("R1 irq", {31'd0, irq}, 32'd0);
    eq("R1 rx_ready", {31'd0, rx_ready}, 32'd0);
    rd_eq("R1 busy", 8'h08, 32'd1);
    rd_eq("R1 rx count", 8'h0C, 32'd0);
    rd_eq("R1 tx count", 8'h10, 32'd0);
    rd_eq("R1 events", 8'h14, 32'd0);

    // R2 identifier, decode and zero registers
    rd_eq("R2 id word 0", 8'h00, 32'h5054_454E);
    rd_eq("R2 id word 1", 8'h04, 32'h3154_524F);
    rd_eq("R2 aliased id word 1", 8'h44, 32'h3154_524F);
    rd_eq("R2 info", 8'h18, 32'd0);
    rd_eq("R2 tx port read", 8'h20, 32'd0);
    rd_eq("R2 unmapped", 8'h24, 32'd0);

    // R3 refused while busy
    push_rx(2, 5, got);
    eq("R3 refused while busy", got, 0);
    rd_eq("R3 count after refusal", 8'h0C, 32'd0);

    // R11 write of zero recomputes busy
    wr(8'h14, 32'd0);
    rd_eq("R11 busy after zero write", 8'h08, 32'd0);

    // R7 ignored while transmit count is zero
    wr(8'h20, 32'h55);
    repeat (2) @(negedge clk);
    #1 eq("R7 no frame from zero count", {31'd0, tx_valid}, 32'd0);
    rd_eq("R7 no event from zero count", 8'h14, 32'd0);

    // R3 R4 R12 receive every length
    for (int n = 1; n <= MAXF; n++) begin
      push_rx(n, 20, got);
      eq("R3 accepted", got, n);
      #1 eq("R12 irq on rx done", {31'd0, irq}, 32'd1);
      rd_eq("R3 rx count", 8'h0C, n);
      rd_eq("R3 busy set", 8'h08, 32'd1);
      rd_eq("R3 rx done bit", 8'h14, 32'd2);
      for (int i = 0; i < n; i++) rd_eq("R4 rx byte", 8'h1C, {24'd0, rpat(n, i)});
      rd_eq("R4 empty read", 8'h1C, 32'd0);
      rd_eq("R4 count drained", 8'h0C, 32'd0);
      wr(8'h14, 32'd2);
      rd_eq("R9 rx done cleared", 8'h14, 32'd0);
      rd_eq("R11 busy released", 8'h08, 32'd0);
      #1 eq("R12 irq low", {31'd0, irq}, 32'd0);
    end

    // R14 over-length frame
    push_rx(MAXF + 3, 30, got);
    eq("R14 whole frame taken", got, MAXF + 3);
    rd_eq("R14 count capped", 8'h0C, MAXF);
    for (int i = 0; i < MAXF; i++) rd_eq("R14 kept byte", 8'h1C, {24'd0, rpat(MAXF + 3, i)});
    wr(8'h14, 32'd2);

    // R5 transmit count sweep
    for (int c = 0; c <= MAXF + 3; c++) begin
      wr(8'h10, c);
      rd_eq("R5 tx count load", 8'h10, (c <= MAXF) ? c : 0);
    end
    wr(8'h10, 32'h8000_0008);
    rd_eq("R5 wide value rejected", 8'h10, 32'd0);

    // R6 R8 transmit every length
    for (int n = 1; n <= MAXF; n++) begin
      send_tx(n);
      rd_eq("R6 tx done bit", 8'h14, 32'd1);
      rd_eq("R6 busy set", 8'h08, 32'd1);
      rd_eq("R6 tx count cleared", 8'h10, 32'd0);
      drain_tx(n, tpat(n, 0));
      wr(8'h14, 32'd1);
      rd_eq("R9 tx done cleared", 8'h14, 32'd0);
      rd_eq("R11 busy released after tx", 8'h08, 32'd0);
    end

    // R7 writes ignored while streaming
    send_tx(3);
    wr(8'h10, 32'd1);
    wr(8'h20, 32'hAB);
    drain_tx(3, tpat(3, 0));
    rd_eq("R7 count kept during stream", 8'h10, 32'd1);
    wr(8'h20, {24'd0, tpat(1, 0)});
    drain_tx(1, tpat(1, 0));
    wr(8'h14, 32'd1);

    // R9 priority with both events pending
    push_rx(2, 20, got);
    send_tx(1);
    drain_tx(1, tpat(1, 0));
    rd_eq("R9 both events", 8'h14, 32'd3);
    wr(8'h14, 32'd3);
    rd_eq("R9 only tx cleared", 8'h14, 32'd2);
    rd_eq("R9 busy kept", 8'h08, 32'd1);
    wr(8'h14, 32'h8000_0002);
    rd_eq("R9 rx cleared without reset", 8'h14, 32'd0);
    rd_eq("R9 rx count kept", 8'h0C, 32'd2);
    rd_eq("R9 busy released", 8'h08, 32'd0);

    // R10 soft reset, R11 read clears test bit
    wr(8'h10, 32'd3);
    wr(8'h20, 32'h11);
    wr(8'h14, 32'h8000_0000);
    #1 eq("R12 irq on test bit", {31'd0, irq}, 32'd1);
    rd_eq("R10 rx count cleared", 8'h0C, 32'd0);
    rd_eq("R10 tx count cleared", 8'h10, 32'd0);
    rd_eq("R10 busy set", 8'h08, 32'd1);
    rd_eq("R11 test bit read", 8'h14, 32'h8000_0000);
    rd_eq("R11 test bit cleared by read", 8'h14, 32'd0);
    #1 eq("R12 irq after read", {31'd0, irq}, 32'd0);
    rd_eq("R11 busy unchanged by read", 8'h08, 32'd1);

    // R13 read-only registers
    wr(8'h08, 32'd0);
    wr(8'h0C, 32'd5);
    wr(8'h18, 32'd7);
    wr(8'h1C, 32'd9);
    wr(8'h00, 32'd1);
    wr(8'h04, 32'd1);
    rd_eq("R13 busy", 8'h08, 32'd1);
    rd_eq("R13 rx count", 8'h0C, 32'd0);
    rd_eq("R13 info", 8'h18, 32'd0);
    rd_eq("R13 id", 8'h00, 32'h5054_454E);
    #1 eq("R13 rx_ready", {31'd0, rx_ready}, 32'd0);

    // R10 byte position restarts after soft reset
    wr(8'h14, 32'd0);
    rd_eq("R11 busy after ack", 8'h08, 32'd0);
    wr(8'h10, 32'd1);
    wr(8'h20, {24'd0, tpat(1, 0)});
    drain_tx(1, tpat(1, 0));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule